// File: doc/BRIEF.md
# Far-End Block Error Event Monitor

This block watches the per-frame far-end block error indication recovered by an E3 receive framer. A frame strobe comes with the decoded error bit. Every frame that arrives with the error bit at 1 is counted in a 16-bit saturating counter and also sets a sticky interrupt status bit. The status bit is gated by an enable vector and drives an interrupt line toward the host.

The host reads the block through a small byte-wide read port made up of an address, a read strobe and a registered read data bus. The counter is read as two bytes. Reading the upper byte captures the lower byte into a shadow register and clears the counter in the same cycle, so the two bytes always come from the same instant. Reading the lower byte afterwards returns that shadow. Every readable register is reset-upon-read. An event that lands in the same cycle as a clearing read is kept, not lost.

Top module: `febe_event_monitor`

## Requirements
- R1: An error event is a cycle with `frame_strobe_i`=1 and `febe_bit_i`=1. Each event adds exactly one to the internal 16-bit count. A strobe with the bit at 0, or the bit at 1 without a strobe, changes nothing.
- R2: After a synchronous active-high reset, the count, the shadow byte and the status byte are 0, and `irq_o` and `rd_data_o` are 0.
- R3: The count saturates at 0xFFFF and never wraps to zero.
- R4: A read at address 1 returns the count's upper byte on `rd_data_o` in the cycle after the strobe. The same edge copies the lower byte into the shadow register and clears the count.
- R5: A read at address 2 returns the shadow byte in the cycle after the strobe, and clears the shadow byte.
- R6: If an event coincides with a read at address 1, the count becomes 1 instead of 0.
- R7: Each event sets bit 4 of the status byte, whatever the enable. A read at address 0 returns the status byte (bits other than 4 always 0) and clears it. An event in the same cycle as that read leaves bit 4 set.
- R8: In the cycle after an edge, `irq_o` is 1 exactly when some status bit is set after that edge and its bit of `irq_enable_i` was 1 at that edge.
- R9: A read at address 3 returns 0. In any cycle that does not follow a read strobe, `rd_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_strobe_i | input | 1 | One-cycle pulse per received frame |
| febe_bit_i | input | 1 | Decoded far-end block error bit of that frame |
| irq_enable_i | input | 8 | Per-bit enable for the status byte |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 2 | Read address (0 status, 1 count high, 2 count low, 3 unused) |
| rd_data_o | output | 8 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Directed sequences separate true events from strobes or bits that arrive alone, which is how R1 is told apart from plain frame counting. Coincident event-and-read cycles on both the count and the status register show whether a clearing read loses an event. A long run of events drives the count into saturation. Random mixes of strobes, error bits, enables and reads at all four addresses then compare every read value and the interrupt line against a bench model in each cycle, so a stale shadow or a wrong clear shows up.

// File: rtl/febe_mon_pkg.sv
package febe_mon_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS = 2'd0,
    REG_CNT_HI = 2'd1,
    REG_CNT_LO = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/febe_event_counter.sv
module febe_event_counter #(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  event_i,
  input  logic                  snap_clr_i,
  input  logic                  lo_clr_i,
  output logic [2*BYTE_W-1:0]   count_o,
  output logic [BYTE_W-1:0]     shadow_o
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (snap_clr_i) begin
      cnt_q <= event_i ? CNT_ONE : '0;
    end else if (event_i && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
    end else if (snap_clr_i) begin
      shadow_q <= cnt_q[BYTE_W-1:0];
    end else if (lo_clr_i) begin
      shadow_q <= '0;
    end
  end

  assign count_o  = cnt_q;
  assign shadow_o = shadow_q;
endmodule

// File: rtl/febe_irq_status.sv
module febe_irq_status #(
  parameter int BYTE_W  = 8,
  parameter int EVT_BIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              event_i,
  input  logic              rd_clr_i,
  input  logic [BYTE_W-1:0] enable_i,
  output logic [BYTE_W-1:0] status_o,
  output logic              irq_o
);
  logic [BYTE_W-1:0] stat_q;
  logic [BYTE_W-1:0] stat_d;
  logic [BYTE_W-1:0] set_vec;
  logic              irq_q;

  for (genvar b = 0; b < BYTE_W; b++) begin : g_src
    if (b == EVT_BIT) begin : g_live
      assign set_vec[b] = event_i;
    end else begin : g_unused
      assign set_vec[b] = 1'b0;
    end
  end

  always_comb begin
    stat_d = rd_clr_i ? set_vec : (stat_q | set_vec);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= |(stat_d & enable_i);
    end
  end

  assign status_o = stat_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/febe_read_mux.sv
module febe_read_mux
  import febe_mon_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  input  logic [BYTE_W-1:0]   status_i,
  input  logic [2*BYTE_W-1:0] count_i,
  input  logic [BYTE_W-1:0]   shadow_i,
  output logic [BYTE_W-1:0]   rd_data_o
);
  logic [BYTE_W-1:0] sel_d;
  logic [BYTE_W-1:0] data_q;

  always_comb begin
    sel_d = '0;
    if (rd_en_i) begin
      unique case (reg_sel_e'(rd_addr_i))
        REG_STATUS: sel_d = status_i;
        REG_CNT_HI: sel_d = count_i[2*BYTE_W-1:BYTE_W];
        REG_CNT_LO: sel_d = shadow_i;
        REG_SPARE:  sel_d = '0;
        default:    sel_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) data_q <= '0;
    else     data_q <= sel_d;
  end

  assign rd_data_o = data_q;
endmodule

// File: rtl/febe_event_monitor.sv
module febe_event_monitor
  import febe_mon_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int EVT_BIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_strobe_i,
  input  logic              febe_bit_i,
  input  logic [BYTE_W-1:0] irq_enable_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int CNT_W = 2 * BYTE_W;

  logic              evt_w;
  logic              hi_rd_w;
  logic              lo_rd_w;
  logic              st_rd_w;
  logic [CNT_W-1:0]  count_w;
  logic [BYTE_W-1:0] shadow_w;
  logic [BYTE_W-1:0] status_w;

  assign evt_w   = frame_strobe_i & febe_bit_i;
  assign hi_rd_w = rd_en_i & (rd_addr_i == REG_CNT_HI);
  assign lo_rd_w = rd_en_i & (rd_addr_i == REG_CNT_LO);
  assign st_rd_w = rd_en_i & (rd_addr_i == REG_STATUS);

  febe_event_counter #(.BYTE_W(BYTE_W)) cnt_i (
    .clk        (clk),
    .rst        (rst),
    .event_i    (evt_w),
    .snap_clr_i (hi_rd_w),
    .lo_clr_i   (lo_rd_w),
    .count_o    (count_w),
    .shadow_o   (shadow_w)
  );

  febe_irq_status #(.BYTE_W(BYTE_W), .EVT_BIT(EVT_BIT)) sts_i (
    .clk      (clk),
    .rst      (rst),
    .event_i  (evt_w),
    .rd_clr_i (st_rd_w),
    .enable_i (irq_enable_i),
    .status_o (status_w),
    .irq_o    (irq_o)
  );

  febe_read_mux #(.BYTE_W(BYTE_W)) mux_i (
    .clk       (clk),
    .rst       (rst),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .status_i  (status_w),
    .count_i   (count_w),
    .shadow_i  (shadow_w),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/febe_event_monitor_chk.sv
module febe_event_monitor_chk #(
  parameter int BYTE_W  = 8,
  parameter int EVT_BIT = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                frame_strobe_i,
  input logic                febe_bit_i,
  input logic [BYTE_W-1:0]   irq_enable_i,
  input logic                rd_en_i,
  input logic [1:0]          rd_addr_i,
  input logic [BYTE_W-1:0]   rd_data_o,
  input logic                irq_o,
  input logic [2*BYTE_W-1:0] count_w,
  input logic [BYTE_W-1:0]   status_w
);
  localparam logic [2*BYTE_W-1:0] MAXV = {(2*BYTE_W){1'b1}};
  logic ev, hi;
  assign ev = frame_strobe_i && febe_bit_i;
  assign hi = rd_en_i && (rd_addr_i == 2'd1);

  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    (ev && !hi && count_w != MAXV) |=> count_w == $past(count_w) + 1'b1);
  p_no_event_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!ev && !hi) |=> $stable(count_w));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (count_w == MAXV && !hi) |=> count_w == MAXV);
  p_hi_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (hi && !ev) |=> count_w == '0);
  p_hit_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (hi && ev) |=> count_w == 1);
  p_status_set_r7: assert property (@(posedge clk) disable iff (rst)
    ev |=> status_w[EVT_BIT]);
  p_irq_fire_r8: assert property (@(posedge clk) disable iff (rst)
    (ev && irq_enable_i[EVT_BIT]) |=> irq_o);
  p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (status_w != '0));
  p_idle_data_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> rd_data_o == '0);
endmodule

bind febe_event_monitor febe_event_monitor_chk #(.BYTE_W(BYTE_W), .EVT_BIT(EVT_BIT)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .frame_strobe_i (frame_strobe_i),
  .febe_bit_i     (febe_bit_i),
  .irq_enable_i   (irq_enable_i),
  .rd_en_i        (rd_en_i),
  .rd_addr_i      (rd_addr_i),
  .rd_data_o      (rd_data_o),
  .irq_o          (irq_o),
  .count_w        (count_w),
  .status_w       (status_w)
);

// File: tb/febe_event_monitor_tb.sv
module febe_event_monitor_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe = 1'b0;
  logic       fbit = 1'b0;
  logic [7:0] en = 8'h00;
  logic       rd = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  string phase_tag = "R2";

  logic [15:0] m_cnt = '0;
  logic [7:0]  m_shadow = '0;
  logic [7:0]  m_stat = '0;
  logic        m_irq = 1'b0;

  always #5 clk = ~clk;

  febe_event_monitor dut_i (
    .clk(clk), .rst(rst), .frame_strobe_i(strobe), .febe_bit_i(fbit),
    .irq_enable_i(en), .rd_en_i(rd), .rd_addr_i(addr),
    .rd_data_o(rdata), .irq_o(irq)
  );

  function automatic logic [7:0] exp_read(input logic r, input logic [1:0] a);
    if (!r) return 8'h00;
    case (a)
      2'd0: return m_stat;
      2'd1: return m_cnt[15:8];
      2'd2: return m_shadow;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string addr_tag(input logic r, input logic [1:0] a);
    if (!r) return "R9";
    case (a)
      2'd0: return "R7";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s/%s actual=%02h expected=%02h", phase_tag, tag, act, exp);
    end
  endtask

  task automatic cycle(input logic s, input logic f, input logic r, input logic [1:0] a);
    logic ev;
    logic [7:0] er;
    strobe = s; fbit = f; rd = r; addr = a;
    @(posedge clk);
    ev = s & f;
    er = exp_read(r, a);
    if (r && a == 2'd1) begin
      m_shadow = m_cnt[7:0];
      m_cnt = ev ? 16'd1 : 16'd0;
    end else begin
      if (r && a == 2'd2) m_shadow = 8'h00;
      if (ev && m_cnt != 16'hFFFF) m_cnt = m_cnt + 16'd1;
    end
    if (r && a == 2'd0) m_stat = ev ? 8'h10 : 8'h00;
    else if (ev) m_stat = m_stat | 8'h10;
    m_irq = |(m_stat & en);
    #1;
    check(addr_tag(r, a), rdata, er);
    check("R8", {7'd0, irq}, {7'd0, m_irq});
    @(negedge clk);
    strobe = 1'b0; fbit = 1'b0; rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R2: reset state through the read port
    phase_tag = "R2";
    check("R2", rdata, 8'h00);
    check("R2", {7'd0, irq}, 8'h00);
    cycle(0, 0, 1, 2'd1);
    cycle(0, 0, 1, 2'd2);
    cycle(0, 0, 1, 2'd0);

    // R1: only strobe with bit at 1 counts
    phase_tag = "R1";
    for (int i = 0; i < 5; i++) cycle(1, 1, 0, 2'd0);
    cycle(1, 0, 0, 2'd0);
    cycle(0, 1, 0, 2'd0);
    cycle(0, 0, 1, 2'd1);
    cycle(0, 0, 1, 2'd2);
    cycle(0, 0, 1, 2'd2);

    // R6: event coinciding with the high-byte read
    phase_tag = "R6";
    for (int i = 0; i < 3; i++) cycle(1, 1, 0, 2'd0);
    cycle(1, 1, 1, 2'd1);
    cycle(0, 0, 1, 2'd1);
    cycle(0, 0, 1, 2'd2);

    // R7 and R8: status set regardless of enable, irq gated
    phase_tag = "R7";
    cycle(0, 0, 1, 2'd0);
    en = 8'h00;
    cycle(1, 1, 0, 2'd0);
    cycle(0, 0, 1, 2'd0);
    cycle(0, 0, 1, 2'd0);
    phase_tag = "R8";
    en = 8'h10;
    cycle(1, 1, 0, 2'd0);
    cycle(0, 0, 0, 2'd0);
    en = 8'hEF;
    cycle(0, 0, 0, 2'd0);
    en = 8'h10;
    phase_tag = "R7";
    cycle(1, 1, 1, 2'd0);
    cycle(0, 0, 1, 2'd0);
    phase_tag = "R9";
    cycle(1, 1, 1, 2'd3);
    cycle(0, 0, 1, 2'd1);
    cycle(0, 0, 1, 2'd2);

    // R3: saturation at 0xFFFF
    phase_tag = "R3";
    for (int i = 0; i < 65540; i++) cycle(1, 1, 0, 2'd0);
    cycle(0, 0, 1, 2'd1);
    cycle(0, 0, 1, 2'd2);
    cycle(0, 0, 1, 2'd0);

    // random mix
    phase_tag = "RND";
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 16) == 0) en = 8'($urandom);
      cycle(1'($urandom % 3 != 0), 1'($urandom), 1'($urandom % 3 == 0), 2'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule